// File: doc/BRIEF.md
# Symmetric I/Q channel filter with live coefficient swap

This block is a 64-tap real FIR filter used as the receive channel filter after a 4:1 decimation stage, at 15.36 MS/s (four samples per 3.84 Mchip/s chip). It filters an I stream and a Q stream in parallel using one shared coefficient set. Only one sample is accepted per `valid_i` pulse, and each accepted sample gives exactly one output pair a fixed number of cycles later.

The impulse response is symmetric. Only 32 signed 14-bit coefficients are stored, and coefficient address k weights both tap k and tap 63-k. The two samples on those taps are pre-added before a single multiply, so each lane needs 32 multipliers.

Coefficients are written one at a time into a shadow bank while the filter keeps running. A commit strobe copies the whole shadow bank into the active bank in a single edge, which makes the swap glitch-free for adaptive filtering. After reset both banks hold a root-raised-cosine set (roll-off 0.22, unity gain near 8192). Results are rounded from Q13 and saturated to 16 bits.

Top module: `sym_fir_iq`

## Requirements
- R1: While `rst_ni` is low and just after it rises, `valid_o` is 0 and both data outputs are 0.
- R2: After reset the active set is the default root-raised-cosine set. Its centre address 31 holds 8000, address 30 holds 6212, address 0 holds 23, and the remaining addresses follow the stored default. An input impulse of 8192 therefore reproduces those values at the output.
- R3: `valid_o` is high exactly 4 cycles after each cycle in which `valid_i` is high, and at no other time.
- R4: Tap j, with j=0 being the newest sample, uses the coefficient at address j for j<32 and address 63-j for j>=32. The output is y = sum of h[j]*x[n-j] over all 64 taps.
- R5: I and Q use the same active set, and each lane depends only on its own input stream.
- R6: A write (`cwr_en_i`, 5-bit `cwr_addr_i`, 14-bit two's-complement `cwr_data_i`) goes only to the shadow bank. It has no effect on outputs until a commit.
- R7: The set used for a sample is the set that is active after the clock edge that captures it. A commit in the same cycle as `valid_i` applies to that sample, and a write in the same cycle as a commit is included in the copy.
- R8: The Q13 sum is rounded by adding 4096 and then shifting right arithmetically by 13 bits. Halves therefore round toward +infinity.
- R9: Rounded results above 32767 output 32767, and results below -32768 output -32768.
- R10: When `valid_i` is low, the sample history does not change. Gaps in the input stream leave the result of the next sample unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| i_data_i | input | 16 | I sample, signed |
| q_data_i | input | 16 | Q sample, signed |
| cwr_en_i | input | 1 | Shadow coefficient write enable |
| cwr_addr_i | input | 5 | Coefficient address 0..31 |
| cwr_data_i | input | 14 | Coefficient value, signed |
| commit_i | input | 1 | Copy shadow bank into active bank |
| valid_o | output | 1 | Output sample strobe |
| i_data_o | output | 16 | Filtered I, signed |
| q_data_o | output | 16 | Filtered Q, signed |

## Verification
Three things can fall in the same cycle: a coefficient commit, the capture of an input sample, and a shadow write to the last address. The bench streams random samples with random gaps. Partway through the stream it raises `commit_i`, `cwr_en_i` and `valid_i` together. The outputs on both sides of that point are compared with a reference model that applies the write, then the copy, and only then filters. A single wrong coefficient, or a set that tears between old and new, shows up as a mismatch in the neighbouring outputs.

// File: rtl/fir_pkg.sv
package fir_pkg;
  localparam int DATA_W  = 16;
  localparam int COEF_W  = 14;
  localparam int N_TAPS  = 64;
  localparam int OUT_W   = 16;
  localparam int FRAC_SH = 13;

  // root-raised-cosine, roll-off 0.22, 4 samples/chip, index 0 = outermost tap
  function automatic logic signed [COEF_W-1:0] dflt_coef(input int k);
    case (k)
      0: return 14'sd23;     1: return 14'sd16;     2: return -14'sd8;    3: return -14'sd31;
      4: return -14'sd39;    5: return -14'sd16;    6: return 14'sd23;    7: return 14'sd62;
      8: return 14'sd62;     9: return 14'sd16;    10: return -14'sd62;  11: return -14'sd117;
      12: return -14'sd93;  13: return -14'sd16;   14: return 14'sd117;  15: return 14'sd209;
      16: return 14'sd138;  17: return -14'sd96;   18: return -14'sd345; 19: return -14'sd394;
      20: return -14'sd116; 21: return 14'sd371;   22: return 14'sd752;  23: return 14'sd661;
      24: return -14'sd17;  25: return -14'sd995;  26: return -14'sd1609; 27: return -14'sd1042;
      28: return 14'sd606;  29: return 14'sd3382;  30: return 14'sd6212; 31: return 14'sd8000;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
  parameter int CW = fir_pkg::COEF_W,
  parameter int NC = fir_pkg::N_TAPS / 2,
  localparam int AW = $clog2(NC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [CW-1:0]   wr_data_i,
  input  logic            commit_i,
  output logic [NC*CW-1:0] act_o
);
  logic [NC*CW-1:0] shd_q, shd_nxt, act_q;

  always_comb begin
    shd_nxt = shd_q;
    if (wr_en_i) shd_nxt[wr_addr_i*CW +: CW] = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NC; k++) begin
        shd_q[k*CW +: CW] <= CW'(fir_pkg::dflt_coef(k));
        act_q[k*CW +: CW] <= CW'(fir_pkg::dflt_coef(k));
      end
    end else begin
      shd_q <= shd_nxt;
      if (commit_i) act_q <= shd_nxt; // same-cycle write is part of the swap
    end
  end

  assign act_o = act_q;

  assert_no_commit_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(act_q));
  assert_commit_copy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !wr_en_i) |=> (act_q == $past(shd_q)));
endmodule

// File: rtl/fir_lane.sv
module fir_lane #(
  parameter int DW    = fir_pkg::DATA_W,
  parameter int CW    = fir_pkg::COEF_W,
  parameter int TAPS  = fir_pkg::N_TAPS,
  parameter int OW    = fir_pkg::OUT_W,
  parameter int SHIFT = fir_pkg::FRAC_SH,
  localparam int NC   = TAPS / 2,
  localparam int PW   = DW + 1 + CW,
  localparam int ACCW = PW + $clog2(NC)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic signed [DW-1:0] x_i,
  input  logic [NC*CW-1:0]     coef_i,
  input  logic                 out_en_i,
  output logic signed [OW-1:0] y_o
);
  localparam longint MAXL = (longint'(1) << (OW-1)) - 1;
  localparam longint MINL = -(longint'(1) << (OW-1));
  localparam logic signed [ACCW-1:0] MAXV = ACCW'(MAXL);
  localparam logic signed [ACCW-1:0] MINV = ACCW'(MINL);
  localparam logic signed [ACCW-1:0] HALF = ACCW'(longint'(1) << (SHIFT-1));

  logic signed [DW-1:0]   dly_q  [TAPS];
  logic signed [PW-1:0]   prod_d [NC];
  logic signed [PW-1:0]   prod_q [NC];
  logic signed [ACCW-1:0] acc_d, sum_q, rnd, shf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TAPS; i++) dly_q[i] <= '0;
    end else if (vld_i) begin
      dly_q[0] <= x_i;
      for (int i = 1; i < TAPS; i++) dly_q[i] <= dly_q[i-1];
    end
  end

  for (genvar k = 0; k < NC; k++) begin : g_fold
    logic signed [DW:0]   fold;
    logic signed [CW-1:0] cf;
    assign fold = $signed({dly_q[k][DW-1], dly_q[k]}) +
                  $signed({dly_q[TAPS-1-k][DW-1], dly_q[TAPS-1-k]});
    assign cf = $signed(coef_i[k*CW +: CW]);
    assign prod_d[k] = fold * cf;
  end

  always_comb begin
    acc_d = '0;
    for (int k = 0; k < NC; k++)
      acc_d = acc_d + {{(ACCW-PW){prod_q[k][PW-1]}}, prod_q[k]};
  end

  assign rnd = sum_q + HALF;
  assign shf = rnd >>> SHIFT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NC; k++) prod_q[k] <= '0;
      sum_q <= '0;
      y_o   <= '0;
    end else begin
      for (int k = 0; k < NC; k++) prod_q[k] <= prod_d[k];
      sum_q <= acc_d;
      if (out_en_i) begin
        if (shf > MAXV)      y_o <= OW'(MAXV);
        else if (shf < MINV) y_o <= OW'(MINV);
        else                 y_o <= shf[OW-1:0];
      end
    end
  end

  assert_hist_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(dly_q[0]));
  assert_sat_hi_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en_i && (shf > MAXV)) |=> (y_o == OW'(MAXV)));
  assert_sat_lo_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en_i && (shf < MINV)) |=> (y_o == OW'(MINV)));
endmodule

// File: rtl/sym_fir_iq.sv
module sym_fir_iq #(
  parameter int DW    = fir_pkg::DATA_W,
  parameter int CW    = fir_pkg::COEF_W,
  parameter int TAPS  = fir_pkg::N_TAPS,
  parameter int OW    = fir_pkg::OUT_W,
  parameter int SHIFT = fir_pkg::FRAC_SH,
  localparam int NC   = TAPS / 2,
  localparam int AW   = $clog2(NC),
  localparam int LAT  = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] i_data_i,
  input  logic signed [DW-1:0] q_data_i,
  input  logic                 cwr_en_i,
  input  logic [AW-1:0]        cwr_addr_i,
  input  logic [CW-1:0]        cwr_data_i,
  input  logic                 commit_i,
  output logic                 valid_o,
  output logic signed [OW-1:0] i_data_o,
  output logic signed [OW-1:0] q_data_o
);
  logic [NC*CW-1:0] act;
  logic [LAT-1:0]   vpipe;
  logic [1:0][DW-1:0] x_in;
  logic [1:0][OW-1:0] y_out;

  fir_coef_bank #(.CW(CW), .NC(NC)) u_bank (
    .clk_i, .rst_ni,
    .wr_en_i(cwr_en_i), .wr_addr_i(cwr_addr_i), .wr_data_i(cwr_data_i),
    .commit_i, .act_o(act)
  );

  // stages: history, products, sum, round/saturate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vpipe <= '0;
    else         vpipe <= {vpipe[LAT-2:0], valid_i};
  end

  assign x_in[0] = i_data_i;
  assign x_in[1] = q_data_i;

  for (genvar c = 0; c < 2; c++) begin : g_lane
    fir_lane #(.DW(DW), .CW(CW), .TAPS(TAPS), .OW(OW), .SHIFT(SHIFT)) u_lane (
      .clk_i, .rst_ni,
      .vld_i(valid_i), .x_i($signed(x_in[c])), .coef_i(act),
      .out_en_i(vpipe[LAT-2]), .y_o(y_out[c])
    );
  end

  assign valid_o  = vpipe[LAT-1];
  assign i_data_o = $signed(y_out[0]);
  assign q_data_o = $signed(y_out[1]);

  assert_lat_on_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##4 valid_o);
  assert_lat_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##4 !valid_o);
endmodule

// File: tb/tb_sym_fir_iq.sv
module tb_sym_fir_iq;
  logic clk = 0, rst_ni = 0;
  logic valid_i = 0, cwr_en_i = 0, commit_i = 0;
  logic signed [15:0] i_data_i = 0, q_data_i = 0;
  logic [4:0]  cwr_addr_i = 0;
  logic [13:0] cwr_data_i = 0;
  logic valid_o;
  logic signed [15:0] i_data_o, q_data_o;

  sym_fir_iq dut (.clk_i(clk), .rst_ni, .valid_i, .i_data_i, .q_data_i, .cwr_en_i,
    .cwr_addr_i, .cwr_data_i, .commit_i, .valid_o, .i_data_o, .q_data_o);

  always #10 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int act [32];
  int shd [32];
  longint hist_i [64];
  longint hist_q [64];
  int exp_i [256];
  int exp_q [256];
  int exp_c [256];
  string exp_t [256];
  int wp = 0, rp = 0;
  string tag = "R2";
  bit done = 0;

  function automatic int dflt(int k);
    int t [32] = '{23,16,-8,-31,-39,-16,23,62,62,16,-62,-117,-93,-16,117,209,
                   138,-96,-345,-394,-116,371,752,661,-17,-995,-1609,-1042,606,3382,6212,8000};
    return t[k];
  endfunction

  function automatic int filt(longint h [64]);
    longint s = 0, r;
    for (int j = 0; j < 64; j++) s += longint'(act[j < 32 ? j : 63-j]) * h[j];
    r = (s + 4096) >>> 13;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic chk(string rq, int act_v, int exp_v, string what);
    tests++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act_v, exp_v);
    end
  endtask

  task automatic monitor();
    if (valid_o) begin
      if (rp == wp) chk("R3", 1, 0, "unexpected valid_o");
      else begin
        chk("R3", cyc, exp_c[rp%256], "output cycle");
        chk(exp_t[rp%256], int'(i_data_o), exp_i[rp%256], "I out");
        chk(exp_t[rp%256], int'(q_data_o), exp_q[rp%256], "Q out (R5)");
        rp++;
      end
    end
  endtask

  task automatic step(bit v, int xi, int xq, bit we, int wa, int wd, bit cm);
    @(negedge clk);
    monitor();
    valid_i = v; i_data_i = 16'(xi); q_data_i = 16'(xq);
    cwr_en_i = we; cwr_addr_i = 5'(wa); cwr_data_i = 14'(wd); commit_i = cm;
    if (we) shd[wa] = wd;
    if (cm) for (int k = 0; k < 32; k++) act[k] = shd[k];
    if (v) begin
      for (int j = 63; j > 0; j--) begin hist_i[j] = hist_i[j-1]; hist_q[j] = hist_q[j-1]; end
      hist_i[0] = longint'(16'(xi) ^ 16'h0) - ((xi & 32'h8000) != 0 ? 65536 : 0);
      hist_i[0] = longint'($signed(16'(xi)));
      hist_q[0] = longint'($signed(16'(xq)));
      exp_i[wp%256] = filt(hist_i); exp_q[wp%256] = filt(hist_q);
      exp_c[wp%256] = cyc + 4; exp_t[wp%256] = tag; wp++;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic load(int val [32], bit do_commit);
    for (int k = 0; k < 32; k++) step(0, 0, 0, 1, k, val[k], do_commit && k == 31);
  endtask

  function automatic int rnd16();
    return int'($signed(16'($urandom)));
  endfunction

  initial begin
    int cs [32];
    int seed;
    seed = $urandom(32'd4242);
    for (int k = 0; k < 32; k++) begin act[k] = dflt(k); shd[k] = dflt(k); end
    for (int j = 0; j < 64; j++) begin hist_i[j] = 0; hist_q[j] = 0; end
    repeat (3) @(negedge clk);
    chk("R1", int'(valid_o), 0, "valid_o in reset");
    chk("R1", int'(i_data_o), 0, "I in reset");
    chk("R1", int'(q_data_o), 0, "Q in reset");
    rst_ni = 1;
    @(negedge clk);
    chk("R1", int'(valid_o), 0, "valid_o after reset");
    chk("R1", int'(q_data_o), 0, "Q after reset");

    // R2/R5: impulse through default set, opposite sign on Q
    tag = "R2";
    step(1, 8192, -8192, 0, 0, 0, 0);
    for (int i = 0; i < 66; i++) step(1, 0, 0, 0, 0, 0, 0);

    // R10: random data with random gaps
    tag = "R10";
    for (int i = 0; i < 300; i++) step($urandom_range(0, 1) == 1, rnd16(), rnd16(), 0, 0, 0, 0);

    // R6: shadow writes while streaming, no commit
    tag = "R6";
    for (int k = 0; k < 32; k++) begin
      cs[k] = int'($urandom_range(0, 16383)) - 8192;
      step(1, rnd16() / 4, rnd16() / 4, 1, k, cs[k], 0);
    end
    for (int i = 0; i < 40; i++) step(1, rnd16() / 4, rnd16() / 4, 0, 0, 0, 0);

    // R7: write + commit + sample in the same cycle, mid-stream
    tag = "R7";
    for (int i = 0; i < 10; i++) step(1, rnd16() / 4, rnd16() / 4, 0, 0, 0, 0);
    step(1, rnd16() / 4, rnd16() / 4, 1, 31, -5000, 1);
    for (int i = 0; i < 10; i++) step(1, rnd16() / 4, rnd16() / 4, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 777, 1);
    for (int i = 0; i < 70; i++) step($urandom_range(0, 3) != 0, rnd16() / 4, rnd16() / 4, 0, 0, 0, 0);

    // R4: single address 5 -> taps 5 and 58
    tag = "R4";
    for (int k = 0; k < 32; k++) cs[k] = (k == 5) ? 1000 : 0;
    load(cs, 1);
    step(1, 16000, 3000, 0, 0, 0, 0);
    for (int i = 0; i < 64; i++) step(1, 0, 0, 0, 0, 0, 0);

    // R8: only centre address, output = (x31 + x32 + 4096) >>> 13
    tag = "R8";
    for (int k = 0; k < 32; k++) cs[k] = (k == 31) ? 1 : 0;
    load(cs, 1);
    for (int i = 0; i < 66; i++) step(1, 2048, -2048, 0, 0, 0, 0);
    for (int i = 0; i < 66; i++) step(1, 2047, -2049, 0, 0, 0, 0);
    for (int i = 0; i < 40; i++) step(1, rnd16(), rnd16(), 0, 0, 0, 0);

    // R9: full-scale set against full-scale inputs
    tag = "R9";
    for (int k = 0; k < 32; k++) cs[k] = 8191;
    load(cs, 1);
    for (int i = 0; i < 70; i++) step(1, 32767, -32768, 0, 0, 0, 0);
    for (int i = 0; i < 70; i++) step(1, -32768, 32767, 0, 0, 0, 0);

    idle(8);
    chk("R3", rp, wp, "outputs delivered");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule